// File: doc/BRIEF.md
# Two-Section Fixed-Point Recursive Filter

This block is a fourth-order fixed-point recursive (IIR) filter. It is built as two second-order sections in series. Each section combines the current sample and its two previous inputs through feed-forward weights `b0..b2`. It then subtracts its two previous outputs weighted by feedback weights `a1, a2`. The sum is formed at full precision, shifted right to remove the coefficient scaling, and clamped to the section's output word. Because each section is clamped and scaled on its own, the recursion cannot wrap around. All coefficients are compile-time parameters.

Samples arrive as 13-bit signed integers on `x` and are widened by sign extension to the 18-bit multiplier width. The filter has no handshake and applies no back-pressure. Every clock cycle with `clken` high consumes one sample and advances both sections by one step. A cycle with `clken` low consumes nothing and freezes every delay register.

The 38-bit result carries 14 fractional bits. The word between the sections is a 24-bit value, also with 14 fractional bits. Default coefficients use 7 fractional bits.

Top module: `iir_cascade`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears every input and output delay register of both sections. `result` reads 0 in the cycle after a reset edge. With zero input after reset, it stays 0.
- R2: When `clken` is low at an edge, `result` and all delay registers keep their values, and the value on `x` is not consumed. Later outputs are identical to a run where the stalled cycle never happened.
- R3: `x` is a 13-bit two's-complement integer, sign-extended to 18 bits. A sample of -4096 after reset gives a result of -2097152 with the default coefficients.
- R4: Each section computes `acc = ((b0*u + b1*u1 + b2*u2) <<< ALIGN) - a1*v1 - a2*v2` at full precision. `u` is the input and `v` is the output. `ALIGN` is the output's fractional bits minus the input's fractional bits: 14 for the first section and 0 for the second. The section output is `acc >>> 7`, then clamped. Default weights are: first section b = (16, 32, 16), a1 = -128, a2 = 32; second section b = (32, 64, 32), a1 = -64, a2 = 16.
- R5: The first section's registered output is the second section's input, so the two sections form one cascade.
- R6: The first section's output is clamped to a 24-bit signed word, with limits 8388607 and -8388608. The second section's output is clamped to 38 bits. A sustained full-scale step drives the first section into its clamp, and the result follows the clamped value.
- R7: `result` is 38-bit signed with 14 fractional bits. A unit impulse after reset produces a first nonzero result of 512, which is 0.125 × 0.25 in that format.
- R8: A sample taken at enabled edge k first affects `result` after enabled edge k+1, so the latency is two enabled edges. After the first enabled edge `result` is still 0.
- R9: The right shift is arithmetic and rounds toward minus infinity (floor). It is bit-exact against an integer model for mixed-sign and full-scale input sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clken | input | 1 | Consumes a sample and advances the filter when high |
| x | input | 13 | Signed integer input sample |
| result | output | 38 | Signed filter output, 14 fractional bits |

## Verification
Every delay register feeds back into the next output, so a corrupted internal value shows at `result` within one or two enabled cycles. Because of the feedback, the error then persists in all later samples rather than being flushed out. A wrong clamp or shift in the first section reaches the port one enabled cycle later, through the second section. A lost or extra advance during a stall shifts the whole impulse response by one sample. The bench therefore compares every cycle against a bit-exact integer model. It also checks fixed values at the impulse, sign and latency corners.

// File: rtl/iir_pkg.sv
package iir_pkg;
  localparam int unsigned FF_TAPS = 3;
  localparam int unsigned FB_TAPS = 2;
  localparam int unsigned GUARD_W = 3;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/iir_clamp.sv
module iir_clamp #(
  parameter int unsigned IN_W  = 51,
  parameter int unsigned OUT_W = 38,
  parameter int unsigned SHIFT = 7
) (
  input  logic signed [IN_W-1:0]  acc,
  output logic signed [OUT_W-1:0] q
);
  localparam logic signed [IN_W-1:0] HI = {{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO = {{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [IN_W-1:0] scaled;

  always_comb begin
    scaled = acc >>> SHIFT;
    if (scaled > HI)      q = HI[OUT_W-1:0];
    else if (scaled < LO) q = LO[OUT_W-1:0];
    else                  q = scaled[OUT_W-1:0];
  end
endmodule

// File: rtl/iir_biquad.sv
module iir_biquad
  import iir_pkg::*;
#(
  parameter int unsigned IN_W     = 18,
  parameter int unsigned OUT_W    = 24,
  parameter int unsigned COEF_W   = 10,
  parameter int unsigned IN_FRAC  = 0,
  parameter int unsigned OUT_FRAC = 14,
  parameter int unsigned CSHIFT   = 7,
  parameter logic signed [COEF_W-1:0] B0 = 10'sd16,
  parameter logic signed [COEF_W-1:0] B1 = 10'sd32,
  parameter logic signed [COEF_W-1:0] B2 = 10'sd16,
  parameter logic signed [COEF_W-1:0] A1 = -10'sd128,
  parameter logic signed [COEF_W-1:0] A2 = 10'sd32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  u,
  output logic signed [OUT_W-1:0] v
);
  localparam int unsigned ALIGN = OUT_FRAC - IN_FRAC;
  localparam int unsigned ACC_W = max2(IN_W + COEF_W + ALIGN, OUT_W + COEF_W) + GUARD_W;

  logic signed [IN_W-1:0]   u_d1, u_d2;
  logic signed [OUT_W-1:0]  v_d1, v_d2;
  logic signed [IN_W-1:0]   ff_in  [FF_TAPS];
  logic signed [COEF_W-1:0] ff_c   [FF_TAPS];
  logic signed [OUT_W-1:0]  fb_in  [FB_TAPS];
  logic signed [COEF_W-1:0] fb_c   [FB_TAPS];
  logic signed [ACC_W-1:0]  ff_p   [FF_TAPS];
  logic signed [ACC_W-1:0]  fb_p   [FB_TAPS];
  logic signed [ACC_W-1:0]  ff_sum, acc;
  logic signed [OUT_W-1:0]  v_next;

  assign ff_in[0] = u;    assign ff_c[0] = B0;
  assign ff_in[1] = u_d1; assign ff_c[1] = B1;
  assign ff_in[2] = u_d2; assign ff_c[2] = B2;
  assign fb_in[0] = v_d1; assign fb_c[0] = A1;
  assign fb_in[1] = v_d2; assign fb_c[1] = A2;

  for (genvar i = 0; i < FF_TAPS; i++) begin : g_ff
    assign ff_p[i] = ACC_W'(ff_c[i]) * ACC_W'(ff_in[i]);
  end
  for (genvar j = 0; j < FB_TAPS; j++) begin : g_fb
    assign fb_p[j] = ACC_W'(fb_c[j]) * ACC_W'(fb_in[j]);
  end

  always_comb begin
    ff_sum = '0;
    for (int i = 0; i < FF_TAPS; i++) ff_sum = ff_sum + ff_p[i];
    acc = ff_sum <<< ALIGN;
    for (int j = 0; j < FB_TAPS; j++) acc = acc - fb_p[j];
  end

  iir_clamp #(.IN_W(ACC_W), .OUT_W(OUT_W), .SHIFT(CSHIFT)) u_clamp (
    .acc (acc),
    .q   (v_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      u_d1 <= '0;
      u_d2 <= '0;
      v_d1 <= '0;
      v_d2 <= '0;
    end else if (en) begin
      u_d1 <= u;
      u_d2 <= u_d1;
      v_d1 <= v_next;
      v_d2 <= v_d1;
    end
  end

  assign v = v_d1;
endmodule

// File: rtl/iir_cascade.sv
module iir_cascade #(
  parameter int unsigned X_W    = 13,
  parameter int unsigned MUL_W  = 18,
  parameter int unsigned COEF_W = 10,
  parameter int unsigned CSHIFT = 7,
  parameter int unsigned FRAC_W = 14,
  parameter int unsigned MID_W  = 24,
  parameter int unsigned RES_W  = 38,
  parameter logic signed [COEF_W-1:0] S1_B0 = 10'sd16,
  parameter logic signed [COEF_W-1:0] S1_B1 = 10'sd32,
  parameter logic signed [COEF_W-1:0] S1_B2 = 10'sd16,
  parameter logic signed [COEF_W-1:0] S1_A1 = -10'sd128,
  parameter logic signed [COEF_W-1:0] S1_A2 = 10'sd32,
  parameter logic signed [COEF_W-1:0] S2_B0 = 10'sd32,
  parameter logic signed [COEF_W-1:0] S2_B1 = 10'sd64,
  parameter logic signed [COEF_W-1:0] S2_B2 = 10'sd32,
  parameter logic signed [COEF_W-1:0] S2_A1 = -10'sd64,
  parameter logic signed [COEF_W-1:0] S2_A2 = 10'sd16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clken,
  input  logic [X_W-1:0]   x,
  output logic [RES_W-1:0] result
);
  localparam int unsigned EXT_W = MUL_W - X_W;

  logic signed [MUL_W-1:0] x_ext;
  logic signed [MID_W-1:0] s1_y;
  logic signed [RES_W-1:0] s2_y;

  // R3: widen the integer sample to the multiplier operand width
  assign x_ext = {{EXT_W{x[X_W-1]}}, x};

  iir_biquad #(
    .IN_W(MUL_W), .OUT_W(MID_W), .COEF_W(COEF_W),
    .IN_FRAC(0), .OUT_FRAC(FRAC_W), .CSHIFT(CSHIFT),
    .B0(S1_B0), .B1(S1_B1), .B2(S1_B2), .A1(S1_A1), .A2(S1_A2)
  ) u_sec1 (
    .clk(clk), .rst(rst), .en(clken), .u(x_ext), .v(s1_y)
  );

  // R5: registered first-section output is the second section's input
  iir_biquad #(
    .IN_W(MID_W), .OUT_W(RES_W), .COEF_W(COEF_W),
    .IN_FRAC(FRAC_W), .OUT_FRAC(FRAC_W), .CSHIFT(CSHIFT),
    .B0(S2_B0), .B1(S2_B1), .B2(S2_B2), .A1(S2_A1), .A2(S2_A2)
  ) u_sec2 (
    .clk(clk), .rst(rst), .en(clken), .u(s1_y), .v(s2_y)
  );

  assign result = s2_y;
endmodule

// File: rtl/iir_cascade_chk.sv
module iir_cascade_chk #(
  parameter int unsigned RES_W = 38,
  parameter int unsigned MID_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             clken,
  input logic [RES_W-1:0] result,
  input logic [MID_W-1:0] s1_y
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  assert_reset_result_R1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (result == '0));

  assert_reset_mid_R1: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (s1_y == '0));

  assert_hold_result_R2: assert property (@(posedge clk) disable iff (rst)
    !clken |=> $stable(result));

  assert_hold_mid_R2: assert property (@(posedge clk) disable iff (rst)
    !clken |=> $stable(s1_y));
endmodule

bind iir_cascade iir_cascade_chk #(.RES_W(RES_W), .MID_W(MID_W)) u_chk (
  .clk(clk), .rst(rst), .clken(clken), .result(result), .s1_y(s1_y)
);

// File: tb/tb_iir_cascade.sv
`timescale 1ns/1ps
module tb_iir_cascade;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clken = 1'b0;
  logic [12:0] x = '0;
  logic [37:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  longint m1x1, m1x2, m1y1, m1y2, m2x1, m2x2, m2y1, m2y2;

  iir_cascade dut (.clk(clk), .rst(rst), .clken(clken), .x(x), .result(result));

  always #5 clk = ~clk;

  function automatic longint clampv(input longint v, input int w);
    longint hi = (64'sd1 <<< (w - 1)) - 1;
    longint lo = -(64'sd1 <<< (w - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint sec(input longint u, u1, u2, v1, v2,
                                 input longint b0, b1, b2, a1, a2,
                                 input int align, input int w);
    longint acc = ((b0 * u + b1 * u1 + b2 * u2) <<< align) - a1 * v1 - a2 * v2;
    return clampv(acc >>> 7, w);
  endfunction

  task automatic model_clear();
    m1x1 = 0; m1x2 = 0; m1y1 = 0; m1y2 = 0;
    m2x1 = 0; m2x2 = 0; m2y1 = 0; m2y2 = 0;
  endtask

  task automatic model_step(input longint xv);
    longint n1, n2;
    n2 = sec(m1y1, m2x1, m2x2, m2y1, m2y2, 32, 64, 32, -64, 16, 0, 38);
    n1 = sec(xv, m1x1, m1x2, m1y1, m1y2, 16, 32, 16, -128, 32, 14, 24);
    m2x2 = m2x1; m2x1 = m1y1; m2y2 = m2y1; m2y1 = n2;
    m1x2 = m1x1; m1x1 = xv;   m1y2 = m1y1; m1y1 = n1;
  endtask

  task automatic check(input string tag, input longint exp);
    longint act = longint'($signed(result));
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s result=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive at negedge, edge, sample at following negedge
  task automatic apply(input int xv, input bit en, input string tag);
    x = 13'(xv);
    clken = en;
    @(posedge clk);
    if (en) model_step(longint'(xv));
    @(negedge clk);
    check(tag, m2y1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    x = 13'h1abc;
    clken = 1'b1;
    @(posedge clk);
    @(posedge clk);
    model_clear();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset clears result", 0);
    for (int i = 0; i < 4; i++) apply(0, 1'b1, "R1 zero input stays zero");
  endtask

  task automatic t_latency_format();
    do_reset();
    apply(1, 1'b1, "R8 first enabled edge");
    check("R8 result still zero after one edge", 0);
    apply(0, 1'b1, "R8 second enabled edge");
    check("R7 unit impulse 0.125*0.25 in 24.14", 512);
    for (int i = 0; i < 20; i++) apply(0, 1'b1, "R5 cascade impulse response");
  endtask

  task automatic t_sign();
    do_reset();
    apply(-4096, 1'b1, "R3 negative full scale edge 1");
    apply(0, 1'b1, "R3 negative full scale edge 2");
    check("R3 sign-extended impulse", -2097152);
    for (int i = 0; i < 10; i++) apply(0, 1'b1, "R4 decay after negative impulse");
  endtask

  task automatic t_step_clamp();
    do_reset();
    for (int i = 0; i < 40; i++) apply(4095, 1'b1, "R6 full-scale step");
    checks++;
    if (m1y1 != 8388607) begin
      fails++;
      $display("FAIL R6 first section model=%0d expected=%0d", m1y1, 64'sd8388607);
    end
    for (int i = 0; i < 40; i++) apply(-4096, 1'b1, "R6 negative full-scale step");
  endtask

  task automatic t_stall();
    longint held;
    do_reset();
    for (int i = 0; i < 5; i++) apply(300 * (i + 1) - 700, 1'b1, "R4 fill before stall");
    held = m2y1;
    for (int i = 0; i < 4; i++) apply(4095 - i * 1000, 1'b0, "R2 stalled cycle");
    check("R2 result frozen across stall", held);
    for (int i = 0; i < 8; i++) apply(-i * 37, 1'b1, "R2 resume after stall");
  endtask

  task automatic t_extremes();
    do_reset();
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom_range(0, 3));
      int xv = (r == 0) ? 4095 : (r == 1) ? -4096 : (int'($urandom_range(0, 8191)) - 4096);
      apply(xv, ($urandom_range(0, 7) != 0), "R9 random extremes bit-exact");
    end
  endtask

  initial begin
    model_clear();
    @(negedge clk);
    t_reset();
    t_latency_format();
    t_sign();
    t_step_clamp();
    t_stall();
    t_extremes();
    t_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog result=%0d expected=completion", result);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule